// File: doc/BRIEF.md
# PLCP Trailer Stuffing Sequencer

This block is the timing sequencer of a transmit PLCP framer carried on a DS3 nibble stream. It keeps track of where the framer is inside the current PLCP frame and reports it as a row number and a nibble index within that row. After the frame body it appends a run of trailer nibbles and asserts a one-cycle frame-boundary pulse on the final nibble of the frame. The datapath uses these outputs to place alignment bytes, overhead bytes, cell data and trailer nibbles.

The trailer length follows a repeating cycle of three frames, called phases. Phase 1 always appends 13 nibbles and phase 2 always appends 14. Phase 3 is the stuff opportunity: it appends 13 nibbles, or 14 when the external stuff-control input was high when the phase began. The sequencer also supplies the cycle/stuff indicator byte for the current frame. A clear-channel mode input forces every phase-3 frame to the unstuffed length. All counters move only on cycles where the nibble-enable strobe is high.

Top module: `plcp_stuff_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the sequencer in phase 1 (`phase` = 0), row 0, nibble 0. After reset, `frame_pulse` and `trailer_active` are low and `c1_value` is 0xFF.
- R2: The frame body is 12 rows of 114 nibbles, 1368 nibbles in all. Each enabled nibble advances `nib_pos` from 0 to 113. After nibble 113, `nib_pos` returns to 0 and `row` increments.
- R3: After the body, `row` reads 12 and `trailer_active` is high for the trailer nibbles only. During the trailer, `nib_pos` counts the trailer nibbles from 0 and `trail_data` reads binary 1100. Outside the trailer, `trail_data` is 0.
- R4: A phase-1 frame (`phase` = 0) carries 13 trailer nibbles, so it is 1381 nibbles long.
- R5: A phase-2 frame (`phase` = 1) carries 14 trailer nibbles, so it is 1382 nibbles long.
- R6: A phase-3 frame (`phase` = 2) carries 14 trailer nibbles when the stuff decision is set and 13 when it is clear. After a phase-3 frame the sequencer returns to phase 1.
- R7: `stuff_in` is sampled only on the enabled nibble that ends the phase-2 frame. Changes to it during the phase-3 frame alter neither that frame's trailer length nor its `c1_value`.
- R8: When `clear_mode` is high at the sampling point, the stuff decision is clear whatever the level of `stuff_in`.
- R9: `c1_value` is 0xFF in phase 1 and 0x00 in phase 2. In phase 3 it is 0x66 without stuff and 0x99 with stuff.
- R10: `frame_pulse` is high only while `nib_en` is high on the last trailer nibble of a frame, once per frame. After that nibble the sequencer is at row 0, nibble 0 of the next phase.
- R11: While `nib_en` is low, `row`, `nib_pos`, `phase` and `c1_value` hold their values and `frame_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nib_en | input | 1 | Nibble strobe; the sequencer advances one nibble when high |
| stuff_in | input | 1 | Stuff request for the next phase-3 frame |
| clear_mode | input | 1 | Clear-channel mode; forces no stuffing |
| phase | output | 2 | Stuffing phase: 0, 1 or 2 for phases 1 to 3 |
| row | output | 4 | Row 0 to 11 in the body, 12 during the trailer |
| nib_pos | output | 7 | Nibble index within the row or trailer |
| trailer_active | output | 1 | High during trailer nibbles |
| trail_data | output | 4 | Trailer nibble value (1100) during the trailer, else 0 |
| c1_value | output | 8 | Cycle/stuff indicator byte for the current frame |
| frame_pulse | output | 1 | High on the final enabled nibble of a frame |

## Verification
The assertions are evaluated every cycle. They check that the counters and indicator byte hold while the strobe is low, that the pulse falls only on a trailer nibble and is followed by row 0, nibble 0, and that phase changes only after a pulse. They also check that the phase-1 and phase-2 indicator bytes are correct, that the trailer value is constant, and that the phase-3 indicator byte cannot change partway through its frame. Only the bench scenarios show the frame lengths of 1381 and 1382 nibbles, the full row and nibble walk, and the stuff decision taken from the input at the right moment. Those scenarios include changes to the input partway through a frame and the clear-channel override.

// File: rtl/plcp_stuff_seq.sv
module plcp_stuff_seq #(
  parameter int ROWS      = 12,
  parameter int ROW_BYTES = 57,
  parameter int TRAIL_MIN = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       nib_en,
  input  logic       stuff_in,
  input  logic       clear_mode,
  output logic [1:0] phase,
  output logic [3:0] row,
  output logic [6:0] nib_pos,
  output logic       trailer_active,
  output logic [3:0] trail_data,
  output logic [7:0] c1_value,
  output logic       frame_pulse
);
  localparam int ROW_NIBS = 2 * ROW_BYTES;
  localparam int NW = 7;
  localparam int RW = 4;

  logic [1:0]    phase_q;
  logic [RW-1:0] row_q;
  logic [NW-1:0] col_q;
  logic          stuff_q;
  logic          extra;
  logic [NW-1:0] trail_len;
  logic          in_trailer, row_end, last_nib;

  assign in_trailer = (row_q == RW'(ROWS));
  assign extra      = (phase_q == 2'd1) || (phase_q == 2'd2 && stuff_q);
  assign trail_len  = NW'(TRAIL_MIN) + NW'(extra);
  assign row_end    = (col_q == NW'(ROW_NIBS - 1));
  assign last_nib   = in_trailer && (col_q == trail_len - NW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 2'd0;
      row_q   <= '0;
      col_q   <= '0;
      stuff_q <= 1'b0;
    end else if (nib_en) begin
      if (last_nib) begin
        row_q   <= '0;
        col_q   <= '0;
        phase_q <= (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
        if (phase_q == 2'd1) stuff_q <= stuff_in & ~clear_mode;
      end else if (!in_trailer && row_end) begin
        col_q <= '0;
        row_q <= row_q + RW'(1);
      end else begin
        col_q <= col_q + NW'(1);
      end
    end
  end

  always_comb begin
    case (phase_q)
      2'd0:    c1_value = 8'hFF;
      2'd1:    c1_value = 8'h00;
      default: c1_value = stuff_q ? 8'h99 : 8'h66;
    endcase
  end

  assign phase          = phase_q;
  assign row            = row_q;
  assign nib_pos        = col_q;
  assign trailer_active = in_trailer;
  assign trail_data     = in_trailer ? 4'b1100 : 4'b0000;
  assign frame_pulse    = nib_en & last_nib;
endmodule

// File: rtl/plcp_stuff_seq_chk.sv
module plcp_stuff_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       nib_en,
  input logic [1:0] phase,
  input logic [3:0] row,
  input logic [6:0] nib_pos,
  input logic       trailer_active,
  input logic [3:0] trail_data,
  input logic [7:0] c1_value,
  input logic       frame_pulse
);
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !nib_en |=> ($stable(row) && $stable(nib_pos) && $stable(phase) && $stable(c1_value)));
  assert_pulse_in_trailer_R10: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> (trailer_active && nib_en));
  assert_pulse_restart_R10: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |=> (row == 4'd0 && nib_pos == 7'd0));
  assert_phase_step_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_pulse |=> $stable(phase));
  assert_phase_legal_R6: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);
  assert_trail_value_R3: assert property (@(posedge clk) disable iff (rst)
    trailer_active |-> trail_data == 4'b1100);
  assert_c1_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 |-> c1_value == 8'hFF) and (phase == 2'd1 |-> c1_value == 8'h00));
  assert_c1_held_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && !frame_pulse) |=> $stable(c1_value));
endmodule

bind plcp_stuff_seq plcp_stuff_seq_chk u_chk (
  .clk(clk), .rst(rst), .nib_en(nib_en), .phase(phase), .row(row),
  .nib_pos(nib_pos), .trailer_active(trailer_active), .trail_data(trail_data),
  .c1_value(c1_value), .frame_pulse(frame_pulse)
);

// File: tb/plcp_stuff_seq_test.sv
module plcp_stuff_seq_test;
  logic clk = 0, rst = 1, nib_en = 0, stuff_in = 0, clear_mode = 0;
  logic [1:0] phase;
  logic [3:0] row;
  logic [6:0] nib_pos;
  logic trailer_active, frame_pulse;
  logic [3:0] trail_data;
  logic [7:0] c1_value;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  plcp_stuff_seq uut (
    .clk(clk), .rst(rst), .nib_en(nib_en), .stuff_in(stuff_in), .clear_mode(clear_mode),
    .phase(phase), .row(row), .nib_pos(nib_pos), .trailer_active(trailer_active),
    .trail_data(trail_data), .c1_value(c1_value), .frame_pulse(frame_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1; nib_en = 0;
    @(negedge clk); @(negedge clk); rst = 0; #1;
    chk(phase == 0 && row == 0 && nib_pos == 0, "R1", "reset position", {phase, row, nib_pos}, 0);
    chk(!frame_pulse && !trailer_active && c1_value == 8'hFF, "R1", "reset flags/c1", c1_value, 255);
  endtask

  // Run one frame; optionally flip stuff_in midway and insert idle cycles.
  task automatic run_frame(input string req, input int exp_phase, input int exp_trail,
                           input logic [7:0] exp_c1, input bit flip, input bit gaps);
    int body = 1368, len = 1368 + exp_trail;
    int pos_bad = 0, trail_bad = 0, c1_bad = 0, pulses = 0, pulse_at = -1, idle_bad = 0;
    chk(phase == 2'(exp_phase), req, "phase at frame start", phase, exp_phase);
    for (int n = 0; n < len; n++) begin
      int er = (n < body) ? n / 114 : 12;
      int ep = (n < body) ? n % 114 : n - body;
      if (gaps && (n % 97 == 5)) begin
        @(negedge clk); nib_en = 0; #1;
        if (frame_pulse || row != 4'(er) || nib_pos != 7'(ep) || c1_value != exp_c1) idle_bad++;
      end
      @(negedge clk); nib_en = 1;
      if (flip && n == 700) stuff_in = ~stuff_in;
      #1;
      if (row != 4'(er) || nib_pos != 7'(ep)) pos_bad++;
      if (trailer_active != (n >= body) || trail_data != ((n >= body) ? 4'b1100 : 4'b0000)) trail_bad++;
      if (c1_value != exp_c1) c1_bad++;
      if (frame_pulse) begin pulses++; pulse_at = n; end
    end
    @(negedge clk); nib_en = 0; #1;
    chk(pos_bad == 0, "R2", {req, " row/nibble walk mismatches"}, pos_bad, 0);
    chk(trail_bad == 0, "R3", {req, " trailer flag/data mismatches"}, trail_bad, 0);
    chk(c1_bad == 0, "R9", {req, " c1 mismatches"}, c1_bad, 0);
    chk(pulses == 1 && pulse_at == len - 1, req, "pulse position (frame length-1)", pulse_at, len - 1);
    chk(row == 0 && nib_pos == 0, "R10", {req, " restart after pulse"}, {row, nib_pos}, 0);
    if (gaps) chk(idle_bad == 0, "R11", "idle cycles moved state", idle_bad, 0);
  endtask

  initial begin
    t_reset();
    stuff_in = 0;
    run_frame("R4", 0, 13, 8'hFF, 0, 0);
    stuff_in = 1;
    run_frame("R5", 1, 14, 8'h00, 0, 0);
    run_frame("R7", 2, 14, 8'h99, 1, 0);        // stuffed, input flipped mid-frame
    stuff_in = 0;
    run_frame("R4", 0, 13, 8'hFF, 0, 0);
    run_frame("R5", 1, 14, 8'h00, 0, 0);
    run_frame("R6", 2, 13, 8'h66, 1, 0);        // unstuffed, input flipped mid-frame
    chk(phase == 0, "R6", "wrap to phase 1", phase, 0);
    clear_mode = 1; stuff_in = 1;
    run_frame("R4", 0, 13, 8'hFF, 0, 0);
    run_frame("R5", 1, 14, 8'h00, 0, 0);
    run_frame("R8", 2, 13, 8'h66, 0, 0);
    clear_mode = 0; stuff_in = 1;
    run_frame("R11", 0, 13, 8'hFF, 0, 1);
    run_frame("R5", 1, 14, 8'h00, 0, 1);
    stuff_in = 0;
    run_frame("R6", 2, 14, 8'h99, 0, 1);
    t_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule